// File: doc/BRIEF.md
# GPIO Interrupt Event Detector

This block watches a bank of general-purpose input pins and turns their activity into one summary interrupt line per processor core. Every pin offers four trigger kinds: two level triggers (pin high, pin low) and two edge triggers (rising, falling). All four are reported side by side in a shared raw-event vector. The pins are first passed through a two-flop synchronizer. Edges are found by comparing the synchronized value with its value one clock earlier.

Edge events are held in sticky flags until software writes a 1 to the matching bit of the clear port. Level events are not stored; they always follow the synchronized pin. Each core supplies its own enable vector, with one bit for each pin and trigger kind. Its interrupt output is the registered OR over all enabled raw events. The cores share the raw events but never each other's enables, so software on either core can read the raw vector to find out which pin fired.

Top module: `gpio_irq_detect`

## Requirements
- R1: Pin p owns bits [4p+3:4p] of the raw-event vector. Bit 0 is level-low, bit 1 is level-high, bit 2 is falling edge and bit 3 is rising edge.
- R2: The level bits are live. They show the pin value two clocks after it changes, through the two synchronizer flops.
- R3: An edge bit is set in the clock after the synchronized pin changes. It stays set after the pin settles or returns, until it is cleared.
- R4: While `clr_wr` is high, a 1 in `clr_data` clears the matching edge bit at the next clock. A 0 bit leaves the event unchanged. Writes to level-bit positions have no effect.
- R5: If a new edge arrives in the same clock as a clear of that edge bit, the bit stays set.
- R6: `irq[c]` is the OR over all bits of raw events AND core c's enable slice `core_en[c*4*NPINS +: 4*NPINS]`. An event enabled only for one core never asserts the other core's line.
- R7: `irq` is registered. It rises one clock after an enabled raw bit sets, and falls one clock after the last enabled raw bit clears or is masked.
- R8: A synchronous active-high reset clears the synchronizer, the edge flags and `irq`. While the pins are low, the raw vector then reads only level-low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPINS | Asynchronous pin levels |
| clr_wr | input | 1 | Clear strobe for the edge flags |
| clr_data | input | 4*NPINS | Write-1-to-clear mask, using the raw layout |
| core_en | input | NCORES*4*NPINS | Per-core enable vectors, core c in slice c |
| raw_events | output | 4*NPINS | Raw level and edge events |
| irq | output | NCORES | Registered summary interrupt per core |

## Verification
The assertions assume that `clr_wr`, `clr_data` and `core_en` are synchronous to `clk` and stable around each rising edge. They also assume that reset is held from time zero. `pin_in` may change at any time. The bench changes every input only on the falling edge. It sets its pins low before it applies reset, so the raw vector after reset is known. The coincident-clear test places the clear strobe in the single cycle in which the synchronized edge is visible. That timing follows from the two-flop latency in R2.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int KINDS  = 4;
  localparam int K_LOW  = 0;
  localparam int K_HIGH = 1;
  localparam int K_FALL = 2;
  localparam int K_RISE = 3;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl,
  input  logic             clr_wr,
  input  logic [1:0]       clr_edge,   // [0] falling, [1] rising
  output logic [KINDS-1:0] nib
);
  logic prev_q, rise_q, fall_q;
  logic rise_set, fall_set, rise_clr, fall_clr;

  assign rise_set = lvl & ~prev_q;
  assign fall_set = ~lvl & prev_q;
  assign rise_clr = clr_wr & clr_edge[1];
  assign fall_clr = clr_wr & clr_edge[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      rise_q <= rise_set | (rise_q & ~rise_clr);
      fall_q <= fall_set | (fall_q & ~fall_clr);
    end
  end

  always_comb begin
    nib         = '0;
    nib[K_LOW]  = ~lvl;
    nib[K_HIGH] = lvl;
    nib[K_FALL] = fall_q;
    nib[K_RISE] = rise_q;
  end

  assert_rise_seen_R1: assert property (@(posedge clk) disable iff (rst)
    (lvl && !prev_q) |=> nib[K_RISE]);
  assert_fall_seen_R1: assert property (@(posedge clk) disable iff (rst)
    (!lvl && prev_q) |=> nib[K_FALL]);
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (nib[K_RISE] && !(clr_wr && clr_edge[1])) |=> nib[K_RISE]);
  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && clr_edge[0] && !(!lvl && prev_q)) |=> !nib[K_FALL]);
  assert_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && clr_edge[1] && lvl && !prev_q) |=> nib[K_RISE]);
endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core #(
  parameter int EW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [EW-1:0] raw,
  input  logic [EW-1:0] en,
  output logic          irq
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(raw & en);
  end

  assign irq = irq_q;

  assert_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !irq);
  assert_fire_R7: assert property (@(posedge clk) disable iff (rst)
    ((raw & en) != '0) |=> irq);
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int NCORES = 2,
  parameter int STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NPINS-1:0]          pin_in,
  input  logic                      clr_wr,
  input  logic [KINDS*NPINS-1:0]    clr_data,
  input  logic [NCORES*KINDS*NPINS-1:0] core_en,
  output logic [KINDS*NPINS-1:0]    raw_events,
  output logic [NCORES-1:0]         irq
);
  localparam int EW = KINDS * NPINS;

  function automatic logic [EW-1:0] lvl_mask();
    logic [EW-1:0] m = '0;
    for (int p = 0; p < NPINS; p++) begin
      m[p*KINDS + K_LOW]  = 1'b1;
      m[p*KINDS + K_HIGH] = 1'b1;
    end
    return m;
  endfunction
  localparam logic [EW-1:0] LVL_MASK = lvl_mask();

  logic [NPINS-1:0] pin_s;

  gpio_irq_sync #(.WIDTH(NPINS), .STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_s)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_irq_pin u_pin (
      .clk      (clk),
      .rst      (rst),
      .lvl      (pin_s[p]),
      .clr_wr   (clr_wr),
      .clr_edge ({clr_data[p*KINDS + K_RISE], clr_data[p*KINDS + K_FALL]}),
      .nib      (raw_events[p*KINDS +: KINDS])
    );
  end

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    gpio_irq_core #(.EW(EW)) u_core (
      .clk (clk),
      .rst (rst),
      .raw (raw_events),
      .en  (core_en[c*EW +: EW]),
      .irq (irq[c])
    );
  end

  assert_lvl_ignore_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && ((clr_data & LVL_MASK) != '0)) |=> ($countones(raw_events & LVL_MASK) == NPINS));
endmodule

// File: tb/gpio_irq_detect_tb.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb;
  localparam int NP = 4;
  localparam int EW = 4 * NP;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin_in = '0;
  logic          clr_wr = 1'b0;
  logic [EW-1:0] clr_data = '0;
  logic [2*EW-1:0] core_en = '0;
  logic [EW-1:0] raw_events;
  logic [1:0]    irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_irq_detect #(.NPINS(NP), .NCORES(2)) u_dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .clr_wr(clr_wr),
    .clr_data(clr_data), .core_en(core_en),
    .raw_events(raw_events), .irq(irq)
  );

  // {pins[3:0], clr[15:0], en0[15:0], en1[15:0], raw[15:0], irq[1:0]}
  localparam int VW = 4 + 16*4 + 2;
  localparam logic [VW-1:0] VEC [12] = '{
    {4'h0, 16'h0000, 16'h0000, 16'h0000, 16'h1111, 2'b00}, // R8 R1 idle
    {4'h1, 16'h0000, 16'h0000, 16'h0000, 16'h111A, 2'b00}, // R1 rise pin0
    {4'h0, 16'h0000, 16'h0000, 16'h0000, 16'h111D, 2'b00}, // R3 sticky rise
    {4'h0, 16'h000C, 16'h0000, 16'h0000, 16'h1111, 2'b00}, // R4 clear edges
    {4'h2, 16'h0000, 16'h0080, 16'h0000, 16'h11A1, 2'b01}, // R6 core0 only
    {4'h2, 16'h0000, 16'h0000, 16'h0080, 16'h11A1, 2'b10}, // R6 core1 only
    {4'h2, 16'h0080, 16'h0000, 16'h0080, 16'h1121, 2'b00}, // R4 clear drops irq
    {4'h2, 16'h0000, 16'h0020, 16'h0010, 16'h1121, 2'b01}, // R2 level high
    {4'h0, 16'h0000, 16'h0020, 16'h0010, 16'h1151, 2'b10}, // R2 level low
    {4'h0, 16'h0001, 16'h0001, 16'h0000, 16'h1151, 2'b01}, // R4 level write ignored
    {4'h8, 16'h0000, 16'h8000, 16'h0040, 16'hA151, 2'b11}, // R6 both cores
    {4'h8, 16'hFFFF, 16'h2000, 16'h0000, 16'h2111, 2'b01}  // R4 clear all
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset raw", 32'(raw_events), 32'h1111);
    chk("R8 reset irq", 32'(irq), 32'h0);

    for (int i = 0; i < 12; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      @(negedge clk);
      core_en  = {v[33:18], v[49:34]};
      clr_data = v[65:50];
      clr_wr   = |v[65:50];
      @(negedge clk);
      clr_wr   = 1'b0;
      clr_data = '0;
      pin_in   = v[69:66];
      repeat (4) @(negedge clk);
      chk($sformatf("R1 R2 R3 R4 vector %0d raw", i), 32'(raw_events), 32'(v[17:2]));
      chk($sformatf("R6 R7 vector %0d irq", i), 32'(irq), 32'(v[1:0]));
    end

    // R5: a clear in the same cycle as a new rising edge of pin2
    core_en = '0;
    pin_in  = 4'hC;
    @(negedge clk);
    @(negedge clk);
    clr_wr = 1'b1; clr_data = 16'h0800;
    @(negedge clk);
    clr_wr = 1'b0; clr_data = '0;
    chk("R5 coincident clear keeps edge", 32'(raw_events[11]), 32'h1);
    @(negedge clk);
    clr_wr = 1'b1; clr_data = 16'h0800;
    @(negedge clk);
    clr_wr = 1'b0; clr_data = '0;
    chk("R4 later clear removes edge", 32'(raw_events[11]), 32'h0);

    // R7: registered irq timing on pin2 falling, core0 only
    core_en = {16'h0000, 16'h0400};
    @(negedge clk);
    pin_in = 4'h8;
    repeat (3) @(negedge clk);
    chk("R3 fall latched", 32'(raw_events[10]), 32'h1);
    chk("R7 irq not yet", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R7 irq one clock later", 32'(irq), 32'h1);
    clr_wr = 1'b1; clr_data = 16'h0400;
    @(negedge clk);
    clr_wr = 1'b0; clr_data = '0;
    chk("R4 fall cleared", 32'(raw_events[10]), 32'h0);
    chk("R7 irq still high", 32'(irq), 32'h1);
    @(negedge clk);
    chk("R7 irq falls", 32'(irq), 32'h0);

    // R8: reset clears pending edges
    pin_in = 4'h0;
    repeat (4) @(negedge clk);
    chk("R3 pin3 fall pending", 32'(raw_events), 32'h5111);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 reset clears edges", 32'(raw_events), 32'h1111);
    chk("R8 irq low after reset", 32'(irq), 32'h0);

    finish_run();
  end
endmodule